// File: doc/BRIEF.md
# Embedded-Operation Status Word Generator

This block forms the 8-bit status word that a flash-style memory returns on its data bus while an internal program or erase operation runs, and after such an operation has failed. The operation itself is sequenced elsewhere. This block receives the operation's kind, its progress flags and its outcome, and it decides on each bus read whether the read returns array data or the status word. When it returns the status word, the block also decides which status bits change.

Reads are registered. The block captures a read on the clock edge where `rd_i` is high and presents the result on `rd_data_o` from that edge onward. The two toggle bits advance at the same edge. The first status read of an operation therefore sees both toggle bits at 0. The block index of a read is address bits 21:17, which gives 32 blocks.

The operation kind encoding on `op_kind_i` is: 2'b00 none, 2'b01 word program, 2'b10 block erase, 2'b11 chip erase.

Top module: `opstat_gen`

## Requirements
- R1: `rd_data_o` resets to 0. A read taken while an operation is active, or while a failure is pending, returns {8'h00, status}. Any other read returns `array_data_i`. In both cases the value appears after the capturing clock edge.
- R2: Bit 7 returns the inverse of `prog_bit7_i` during a word program and 0 during an erase. After a program failure, bit 7 keeps the inverse of the value that was sampled when the failure was reported.
- R3: Bit 6 reads 0 on the first status read of an operation and inverts after every status read. It keeps inverting after a failure until the failure is cleared.
- R4: Bit 5 becomes 1 after `op_fail_i` is seen while the operation is active. It stays at 1 until `reset_cmd_i` is seen while no operation is active.
- R5: Bit 4 becomes 1 if `vpp_ok_i` is low on any cycle of an active operation. It is cleared together with the failure.
- R6: Bit 3 reads 1 once `erase_started_i` has been seen during an erase. It reads 0 before that and during a word program.
- R7: During a block erase, bit 2 inverts after a status read only when the read address lies in block `erase_blk_i`. A read of any other block leaves bit 2 steady. During a chip erase, every block counts as erasing. During a word program, bit 2 stays steady.
- R8: After an erase failure, bit 2 inverts only on reads of blocks whose `blk_fail_i` bit is set. It stays steady on reads of all other blocks.
- R9: Bit 0 mirrors `mw_ready_i`, and bit 1 reads 0.
- R10: `reset_cmd_i` has no effect while an operation is active. When an operation ends without failure, reads return array data and the next operation starts with both toggle bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_active_i | input | 1 | An embedded operation is running |
| op_kind_i | input | 2 | Kind of the running operation |
| op_fail_i | input | 1 | The running operation failed (pulse) |
| erase_started_i | input | 1 | The erase pulses have begun |
| prog_bit7_i | input | 1 | Bit 7 of the word being programmed |
| erase_blk_i | input | 5 | Index of the block under block erase |
| blk_fail_i | input | 32 | Per-block erase-failure flags |
| vpp_ok_i | input | 1 | High programming voltage present |
| mw_ready_i | input | 1 | Multi-word program ready flag |
| reset_cmd_i | input | 1 | Reset command decoded (pulse) |
| rd_i | input | 1 | Bus read strobe |
| rd_addr_i | input | 22 | Bus read address |
| array_data_i | input | 16 | Array word at the read address |
| rd_data_o | output | 16 | Read result |

## Verification
The main status path is exercised with four kinds of operation: a word program with bit 7 set, a word program that fails with bit 7 clear, a block erase, and an erase that fails under a supply drop. Together these separate the inverted-data rule from the erase rule for bit 7. They also show that the captured bit 7 is held after a failure, even after the live input changes.

Each operation alternates reads between the erasing or failed blocks and other blocks. This pattern separates per-block toggling from global toggling of bit 2. A chip erase is read at the lowest and the highest block to show that every block counts as erasing.

Reset commands are issued both during an operation and after a failure. The bench then checks whether the toggle sequence continued or restarted, which shows whether the command was ignored or acted on.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_PROG   = 2'b01,
    OP_BERASE = 2'b10,
    OP_CERASE = 2'b11
  } op_kind_e;

  function automatic logic is_erase(op_kind_e k);
    return (k == OP_BERASE) || (k == OP_CERASE);
  endfunction
endpackage

// File: rtl/opstat_tgl.sv
module opstat_tgl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flip_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (flip_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/opstat_hold.sv
module opstat_hold
  import opstat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     active_i,
  input  logic     fail_i,
  input  op_kind_e kind_i,
  input  logic     bit7_i,
  input  logic     ers_start_i,
  input  logic     vpp_ok_i,
  output logic     failed_o,
  output logic     vpp_err_o,
  output logic     ers_o,
  output op_kind_e kind_o,
  output logic     bit7_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      failed_o  <= 1'b0;
      vpp_err_o <= 1'b0;
      ers_o     <= 1'b0;
      kind_o    <= OP_NONE;
      bit7_o    <= 1'b0;
    end else if (clr_i) begin
      failed_o  <= 1'b0;
      vpp_err_o <= 1'b0;
      ers_o     <= 1'b0;
      kind_o    <= OP_NONE;
      bit7_o    <= 1'b0;
    end else if (active_i) begin
      if (fail_i) begin
        failed_o <= 1'b1;
        kind_o   <= kind_i;
        bit7_o   <= bit7_i;
      end
      if (!vpp_ok_i) vpp_err_o <= 1'b1;
      if (is_erase(kind_i) && ers_start_i) ers_o <= 1'b1;
    end
  end
endmodule

// File: rtl/opstat_blkhit.sv
module opstat_blkhit
  import opstat_pkg::*;
#(
  parameter int BLK_W   = 5,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               active_i,
  input  logic               failed_i,
  input  op_kind_e           kind_i,
  input  logic [BLK_W-1:0]   rd_blk_i,
  input  logic [BLK_W-1:0]   erase_blk_i,
  input  logic [NUM_BLK-1:0] blk_fail_i,
  output logic               hot_o
);
  always_comb begin
    if (active_i)
      hot_o = (kind_i == OP_CERASE) ||
              ((kind_i == OP_BERASE) && (rd_blk_i == erase_blk_i));
    else
      hot_o = failed_i && is_erase(kind_i) && blk_fail_i[rd_blk_i];
  end
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
  import opstat_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int BLK_LSB = 17,
  parameter int DATA_W  = 16,
  localparam int BLK_W   = ADDR_W - BLK_LSB,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_active_i,
  input  logic [1:0]         op_kind_i,
  input  logic               op_fail_i,
  input  logic               erase_started_i,
  input  logic               prog_bit7_i,
  input  logic [BLK_W-1:0]   erase_blk_i,
  input  logic [NUM_BLK-1:0] blk_fail_i,
  input  logic               vpp_ok_i,
  input  logic               mw_ready_i,
  input  logic               reset_cmd_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [DATA_W-1:0]  array_data_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  op_kind_e         kind_live, kind_q, kind_eff;
  logic             failed, vpp_err, ers, bit7_q, bit7_eff;
  logic             show, clr, hot, tgl6, tgl2;
  logic [BLK_W-1:0] rd_blk;
  logic [7:0]       status;

  assign kind_live = op_kind_e'(op_kind_i);
  assign rd_blk    = rd_addr_i[BLK_LSB +: BLK_W];
  assign show      = op_active_i | failed;
  // reset command acts only outside an operation; idle also closes the session
  assign clr       = !op_active_i && (reset_cmd_i || !failed);
  assign kind_eff  = op_active_i ? kind_live : kind_q;
  assign bit7_eff  = op_active_i ? prog_bit7_i : bit7_q;

  opstat_hold i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .active_i   (op_active_i),
    .fail_i     (op_fail_i),
    .kind_i     (kind_live),
    .bit7_i     (prog_bit7_i),
    .ers_start_i(erase_started_i),
    .vpp_ok_i   (vpp_ok_i),
    .failed_o   (failed),
    .vpp_err_o  (vpp_err),
    .ers_o      (ers),
    .kind_o     (kind_q),
    .bit7_o     (bit7_q)
  );

  opstat_blkhit #(.BLK_W(BLK_W)) i_blkhit (
    .active_i   (op_active_i),
    .failed_i   (failed),
    .kind_i     (kind_eff),
    .rd_blk_i   (rd_blk),
    .erase_blk_i(erase_blk_i),
    .blk_fail_i (blk_fail_i),
    .hot_o      (hot)
  );

  opstat_tgl i_tgl6 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .flip_i(rd_i && show),
    .q_o   (tgl6)
  );

  opstat_tgl i_tgl2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .flip_i(rd_i && show && hot),
    .q_o   (tgl2)
  );

  always_comb begin
    status    = '0;
    status[7] = (kind_eff == OP_PROG) ? ~bit7_eff : 1'b0;
    status[6] = tgl6;
    status[5] = failed;
    status[4] = vpp_err;
    status[3] = ers;
    status[2] = tgl2;
    status[1] = 1'b0;
    status[0] = mw_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= show ? {{(DATA_W-8){1'b0}}, status} : array_data_i;
  end
endmodule

// File: rtl/opstat_chk.sv
module opstat_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_active_i,
  input logic              vpp_ok_i,
  input logic              reset_cmd_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              show,
  input logic              failed,
  input logic              vpp_err,
  input logic              hot,
  input logic              tgl6,
  input logic              tgl2
);
  assert_idle_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !show |=> rd_data_o == $past(array_data_i));

  assert_dq6_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && show && !(reset_cmd_i && !op_active_i) |=> tgl6 != $past(tgl6));

  assert_fail_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failed && !(reset_cmd_i && !op_active_i) |=> failed);

  assert_vpp_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_active_i && !vpp_ok_i |=> vpp_err);

  assert_dq2_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && show && !hot && !(reset_cmd_i && !op_active_i) |=> $stable(tgl2));

  assert_reserved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && show |=> rd_data_o[DATA_W-1:8] == '0 && rd_data_o[1] == 1'b0);
endmodule

bind opstat_gen opstat_chk #(.DATA_W(DATA_W)) i_opstat_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_active_i (op_active_i),
  .vpp_ok_i    (vpp_ok_i),
  .reset_cmd_i (reset_cmd_i),
  .rd_i        (rd_i),
  .array_data_i(array_data_i),
  .rd_data_o   (rd_data_o),
  .show        (show),
  .failed      (failed),
  .vpp_err     (vpp_err),
  .hot         (hot),
  .tgl6        (tgl6),
  .tgl2        (tgl2)
);

// File: tb/test_opstat_gen.sv
module test_opstat_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ARR = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_active = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic        op_fail = 1'b0;
  logic        erase_started = 1'b0;
  logic        prog_bit7 = 1'b0;
  logic [4:0]  erase_blk = '0;
  logic [31:0] blk_fail = '0;
  logic        vpp_ok = 1'b1;
  logic        mw_ready = 1'b0;
  logic        reset_cmd = 1'b0;
  logic        rd = 1'b0;
  logic [21:0] rd_addr = '0;
  logic [15:0] array_data = ARR;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic e6, e2;

  always #(CLK_PERIOD/2) clk = ~clk;

  opstat_gen i_opstat_gen (
    .clk_i(clk), .rst_ni(rst_n), .op_active_i(op_active), .op_kind_i(op_kind),
    .op_fail_i(op_fail), .erase_started_i(erase_started), .prog_bit7_i(prog_bit7),
    .erase_blk_i(erase_blk), .blk_fail_i(blk_fail), .vpp_ok_i(vpp_ok),
    .mw_ready_i(mw_ready), .reset_cmd_i(reset_cmd), .rd_i(rd), .rd_addr_i(rd_addr),
    .array_data_i(array_data), .rd_data_o(rd_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [4:0] blk);
    @(negedge clk);
    rd = 1'b1;
    rd_addr = {blk, 17'h00A5A};
    @(negedge clk);
    rd = 1'b0;
  endtask

  // fixed: status bits other than the two toggle bits
  task automatic rd_status(input string tag, input logic [4:0] blk, input bit hot,
                           input logic [7:0] fixed);
    logic [7:0] exp;
    bus_read(blk);
    exp = fixed;
    exp[6] = e6;
    exp[2] = e2;
    check(tag, rd_data, {8'h00, exp});
    e6 = ~e6;
    if (hot) e2 = ~e2;
  endtask

  task automatic rd_array(input string tag);
    bus_read(5'd9);
    check(tag, rd_data, ARR);
  endtask

  task automatic pulse_reset_cmd();
    reset_cmd = 1'b1;
    tick();
    reset_cmd = 1'b0;
  endtask

  task automatic fail_pulse();
    op_fail = 1'b1;
    tick();
    op_fail = 1'b0;
    op_active = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 16'h0000);
    rst_n = 1'b1;
    tick();
    rd_array("R1 idle read returns array");
  endtask

  task automatic t_program();
    e6 = 0; e2 = 0;
    op_kind = 2'b01; prog_bit7 = 1'b1; mw_ready = 1'b1; op_active = 1'b1;
    rd_status("R2 R9 program first read", 5'd0, 0, 8'h01);
    pulse_reset_cmd();
    rd_status("R10 reset ignored while active", 5'd0, 0, 8'h01);
    rd_status("R3 dq6 toggles again", 5'd4, 0, 8'h01);
    op_active = 1'b0; mw_ready = 1'b0;
    tick();
    rd_array("R10 array after success");
  endtask

  task automatic t_program_fail();
    e6 = 0; e2 = 0;
    op_kind = 2'b01; prog_bit7 = 1'b0; op_active = 1'b1;
    rd_status("R2 program inverse of bit7", 5'd1, 0, 8'h80);
    fail_pulse();
    prog_bit7 = 1'b1;
    rd_status("R4 fail sets dq5, R2 bit7 held", 5'd1, 0, 8'hA0);
    rd_status("R3 dq6 toggles after failure", 5'd2, 0, 8'hA0);
    pulse_reset_cmd();
    rd_array("R4 reset cmd clears failure");
    e6 = 0; e2 = 0;
    op_active = 1'b1;
    rd_status("R10 toggles restart next op", 5'd1, 0, 8'h00);
    op_active = 1'b0;
    tick();
  endtask

  task automatic t_block_erase();
    e6 = 0; e2 = 0;
    op_kind = 2'b10; erase_blk = 5'd3; op_active = 1'b1;
    rd_status("R6 dq3 low before start, R7 hot", 5'd3, 1, 8'h00);
    rd_status("R7 other block steady", 5'd5, 0, 8'h00);
    erase_started = 1'b1;
    tick();
    rd_status("R6 dq3 after start", 5'd3, 1, 8'h08);
    rd_status("R7 erasing block toggles", 5'd3, 1, 8'h08);
    rd_status("R7 other block steady 2", 5'd30, 0, 8'h08);
    op_active = 1'b0; erase_started = 1'b0;
    tick();
    rd_array("R10 array after erase");
  endtask

  task automatic t_erase_fail();
    e6 = 0; e2 = 0;
    op_kind = 2'b10; erase_blk = 5'd6; op_active = 1'b1; erase_started = 1'b1;
    tick();
    vpp_ok = 1'b0;
    tick();
    vpp_ok = 1'b1;
    rd_status("R5 vpp drop flagged", 5'd6, 1, 8'h18);
    blk_fail = 32'h0000_0040;
    fail_pulse();
    erase_started = 1'b0;
    rd_status("R8 failed block toggles", 5'd6, 1, 8'h38);
    rd_status("R8 good block steady", 5'd2, 0, 8'h38);
    rd_status("R8 good block steady 2", 5'd3, 0, 8'h38);
    rd_status("R8 failed block toggles 2", 5'd6, 1, 8'h38);
    pulse_reset_cmd();
    blk_fail = '0;
    rd_array("R5 R4 cleared by reset cmd");
  endtask

  task automatic t_chip_erase();
    e6 = 0; e2 = 0;
    op_kind = 2'b11; op_active = 1'b1; erase_started = 1'b1; mw_ready = 1'b1;
    tick();
    rd_status("R7 chip erase block 0", 5'd0, 1, 8'h09);
    rd_status("R7 chip erase block 31", 5'd31, 1, 8'h09);
    rd_status("R9 dq0 mirrors ready", 5'd17, 1, 8'h09);
    op_active = 1'b0; erase_started = 1'b0; mw_ready = 1'b0;
    tick();
    rd_array("R1 array after chip erase");
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_program();
    t_program_fail();
    t_block_erase();
    t_erase_fail();
    t_chip_erase();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule